// File: doc/BRIEF.md
# Cartridge Bank Mapper with Boot Lock

This block sits between a CPU's 20-bit address bus and the cartridge memories. The CPU address space is divided into sixteen 64 KiB segments, selected by the top four address bits. Four 8-bit bank registers, loaded over a small byte-wide I/O port bus, steer each segment to a linear ROM address, to a linear SRAM address, or to nothing. One register covers twelve segments at once: its value forms the upper bits of the ROM bank and the segment number forms the lower bits.

A system control register carries a sticky lock bit. Until software sets that bit, the top segment is claimed by an internal boot ROM overlay and is not translated to the cartridge. Once set, the bit stays set until reset, so the overlay can never come back. Size masks supplied by the surrounding system trim bank numbers so that banks beyond the fitted ROM or SRAM wrap.

Translation and register reads are both registered: the outputs follow their inputs by one clock.

Top module: `cart_bank_map`

## Requirements
- R1: After synchronous reset all four bank registers hold 0xFF, the lock bit is clear, the control register reads 0x80 and bank register 0 reads 0x2F.
- R2: For segments 4 to 15 (lock set for 15), sel_rom is 1 and lin_addr is {({bank0, segment}) AND rom_mask, cpu_addr[15:0]}, a 12-bit ROM bank above a 16-bit offset.
- R3: Segment 1 gives sel_sram = 1 and lin_addr = {(bank1 AND sram_mask), cpu_addr[15:0]} zero-extended, but only while sram_present is 1; otherwise nothing is selected and lin_addr is 0.
- R4: Segments 2 and 3 give sel_rom = 1 with ROM bank equal to bank register 2 or 3 respectively (zero-extended to 12 bits, then masked by rom_mask).
- R5: Segment 0 selects nothing: sel_rom, sel_sram and overlay_active are 0 and lin_addr is 0.
- R6: Bit 0 of the control register (port 0xA0) is the lock bit; a write with bit 0 set sets it, and later writes with bit 0 clear leave it set until reset.
- R7: A read of the control register returns bit 7 as 1 always, bits 6..1 as last written, and bit 0 as the lock bit.
- R8: While the lock bit is clear, an access to segment 15 drives overlay_active = 1, sel_rom = 0, sel_sram = 0 and lin_addr = 0; at most one of the three select outputs is ever high.
- R9: Bank registers sit at ports 0xC0 to 0xC3 (register n at 0xC0+n); reads of 0xC1 to 0xC3 return the value written, a read of 0xC0 returns 0x20 OR its low nibble.
- R10: A read of any other port returns 0x90, and a write to any other port changes no bank register and no translation.
- R11: The translation outputs reflect cpu_addr sampled at the previous clock edge; io_rdata is loaded one clock after io_rd is high and holds its value while io_rd is low.
- R12: Bank numbers larger than the mask allows wrap: only bank bits that are 1 in rom_mask or sram_mask reach lin_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 20 | CPU address: segment in bits 19..16, offset below |
| io_addr | input | 8 | I/O port number |
| io_wr | input | 1 | Port write strobe |
| io_wdata | input | 8 | Port write data |
| io_rd | input | 1 | Port read strobe |
| io_rdata | output | 8 | Registered port read data |
| rom_mask | input | 12 | ROM bank mask |
| sram_mask | input | 8 | SRAM bank mask |
| sram_present | input | 1 | Cartridge carries SRAM |
| lin_addr | output | 28 | Linear ROM or SRAM address |
| sel_rom | output | 1 | lin_addr addresses ROM |
| sel_sram | output | 1 | lin_addr addresses SRAM |
| overlay_active | output | 1 | Access hits the boot ROM overlay |

## Verification
The bench builds the block with its default widths: 4 segment bits, 16 offset bits and 8-bit bank registers, which makes the ROM bank 12 bits wide and the linear address 28 bits. With those widths every segment role is reachable, including the concatenated twelve-segment window and the overlay on segment 15. The masks are changed at run time between full width and narrow values, so wrap-around of every bank source is exercised alongside random register contents and addresses, both before and after the lock is set.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  localparam int NUM_BANKS = 4;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_SRAM = 2'd2,
    TGT_BOOT = 2'd3
  } tgt_e;

  localparam logic [7:0] OPEN_BUS_VAL = 8'h90;
  localparam logic [7:0] BANK0_TAG    = 8'h20;

  // Decide where a segment goes. Segment 0 is untranslated, segment 1 is
  // SRAM when fitted, the top segment belongs to the boot overlay until
  // the lock is set, everything else is ROM.
  function automatic tgt_e classify(input int unsigned seg,
                                    input int unsigned top_seg,
                                    input logic        sram_en,
                                    input logic        locked);
    tgt_e t;
    if (seg == 0)                       t = TGT_NONE;
    else if (seg == 1)                  t = sram_en ? TGT_SRAM : TGT_NONE;
    else if (seg == top_seg && !locked) t = TGT_BOOT;
    else                                t = TGT_ROM;
    return t;
  endfunction

endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int                IO_AW          = 8,
  parameter int                BANK_W         = 8,
  parameter logic [IO_AW-1:0]  PORT_BANK_BASE = 8'hC0,
  parameter logic [IO_AW-1:0]  PORT_CTL       = 8'hA0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [IO_AW-1:0]                  io_addr,
  input  logic                              io_wr,
  input  logic [BANK_W-1:0]                 io_wdata,
  input  logic                              io_rd,
  output logic [BANK_W-1:0]                 io_rdata,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_q,
  output logic                              lock_q
);

  localparam logic [BANK_W-1:0] TAG_BITS = BANK_W'(BANK0_TAG);
  localparam logic [BANK_W-1:0] OPEN_BUS = BANK_W'(OPEN_BUS_VAL);

  logic [BANK_W-1:0] ctl_q;
  logic [BANK_W-1:0] rd_val;
  logic              any_hit;

  // One register per bank, each decoding its own port.
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam logic [IO_AW-1:0] MY_PORT = IO_AW'(PORT_BANK_BASE + g);
    logic [BANK_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                             r <= '1;
      else if (io_wr && io_addr == MY_PORT) r <= io_wdata;
    end
    assign bank_q[g] = r;
  end

  // Control register: bit 0 can only be set, never cleared by software.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (io_wr && io_addr == PORT_CTL) begin
      ctl_q <= {io_wdata[BANK_W-1:1], io_wdata[0] | ctl_q[0]};
    end
  end

  assign lock_q = ctl_q[0];

  always_comb begin
    rd_val  = OPEN_BUS;
    any_hit = 1'b0;
    if (io_addr == PORT_CTL) begin
      rd_val  = {1'b1, ctl_q[BANK_W-2:0]};
      any_hit = 1'b1;
    end
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (io_addr == IO_AW'(PORT_BANK_BASE + i)) begin
        any_hit = 1'b1;
        if (i == 0) rd_val = TAG_BITS | BANK_W'(bank_q[0][3:0]);
        else        rd_val = bank_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_val;
  end

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  assert_ctl_handshake_R7: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == PORT_CTL) |=> io_rdata[BANK_W-1]);

  assert_open_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !any_hit) |=> io_rdata == OPEN_BUS);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
  import cbm_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 16,
  parameter int BANK_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [SEG_W+OFF_W-1:0]            cpu_addr,
  input  logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_q,
  input  logic                              lock_q,
  input  logic                              sram_present,
  input  logic [BANK_W+SEG_W-1:0]           rom_mask,
  input  logic [BANK_W-1:0]                 sram_mask,
  output logic [BANK_W+SEG_W+OFF_W-1:0]     lin_addr,
  output logic                              sel_rom,
  output logic                              sel_sram,
  output logic                              overlay_active
);

  localparam int ADDR_W     = SEG_W + OFF_W;
  localparam int ROM_BANK_W = BANK_W + SEG_W;
  localparam int LIN_W      = ROM_BANK_W + OFF_W;
  localparam int TOP_SEG    = (1 << SEG_W) - 1;

  logic [SEG_W-1:0]      seg;
  logic [OFF_W-1:0]      off;
  tgt_e                  tgt;
  logic [ROM_BANK_W-1:0] rom_raw;
  logic [BANK_W-1:0]     sram_bank;

  assign seg = cpu_addr[ADDR_W-1 -: SEG_W];
  assign off = cpu_addr[OFF_W-1:0];

  always_comb begin
    tgt = classify(32'(seg), TOP_SEG, sram_present, lock_q);
    case (seg)
      SEG_W'(2): rom_raw = ROM_BANK_W'(bank_q[2]);
      SEG_W'(3): rom_raw = ROM_BANK_W'(bank_q[3]);
      default:   rom_raw = {bank_q[0], seg};
    endcase
    sram_bank = bank_q[1] & sram_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lin_addr       <= '0;
      sel_rom        <= 1'b0;
      sel_sram       <= 1'b0;
      overlay_active <= 1'b0;
    end else begin
      lin_addr       <= '0;
      sel_rom        <= 1'b0;
      sel_sram       <= 1'b0;
      overlay_active <= 1'b0;
      case (tgt)
        TGT_ROM: begin
          sel_rom  <= 1'b1;
          lin_addr <= {rom_raw & rom_mask, off};
        end
        TGT_SRAM: begin
          sel_sram <= 1'b1;
          lin_addr <= LIN_W'({sram_bank, off});
        end
        TGT_BOOT: overlay_active <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_rom, sel_sram, overlay_active}));

  assert_seg0_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (seg == '0) |=> (!sel_rom && !sel_sram && !overlay_active && lin_addr == '0));

  assert_overlay_R8: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_W'(TOP_SEG) && !lock_q) |=> (overlay_active && !sel_rom));

  assert_sram_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_W'(1) && !sram_present) |=> !sel_sram);

endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
  import cbm_pkg::*;
#(
  parameter int               SEG_W          = 4,
  parameter int               OFF_W          = 16,
  parameter int               BANK_W         = 8,
  parameter int               IO_AW          = 8,
  parameter logic [IO_AW-1:0] PORT_BANK_BASE = 8'hC0,
  parameter logic [IO_AW-1:0] PORT_CTL       = 8'hA0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [SEG_W+OFF_W-1:0]            cpu_addr,
  input  logic [IO_AW-1:0]                  io_addr,
  input  logic                              io_wr,
  input  logic [BANK_W-1:0]                 io_wdata,
  input  logic                              io_rd,
  output logic [BANK_W-1:0]                 io_rdata,
  input  logic [BANK_W+SEG_W-1:0]           rom_mask,
  input  logic [BANK_W-1:0]                 sram_mask,
  input  logic                              sram_present,
  output logic [BANK_W+SEG_W+OFF_W-1:0]     lin_addr,
  output logic                              sel_rom,
  output logic                              sel_sram,
  output logic                              overlay_active
);

  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;
  logic                             lock_q;

  cbm_regs #(
    .IO_AW          (IO_AW),
    .BANK_W         (BANK_W),
    .PORT_BANK_BASE (PORT_BANK_BASE),
    .PORT_CTL       (PORT_CTL)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .bank_q   (bank_q),
    .lock_q   (lock_q)
  );

  cbm_xlate #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .BANK_W (BANK_W)
  ) u_xlate (
    .clk            (clk),
    .rst            (rst),
    .cpu_addr       (cpu_addr),
    .bank_q         (bank_q),
    .lock_q         (lock_q),
    .sram_present   (sram_present),
    .rom_mask       (rom_mask),
    .sram_mask      (sram_mask),
    .lin_addr       (lin_addr),
    .sel_rom        (sel_rom),
    .sel_sram       (sel_sram),
    .overlay_active (overlay_active)
  );

endmodule

// File: tb/cart_bank_map_tb.sv
module cart_bank_map_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] cpu_addr = '0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [11:0] rom_mask = 12'hFFF;
  logic [7:0]  sram_mask = 8'hFF;
  logic        sram_present = 1'b1;
  logic [27:0] lin_addr;
  logic        sel_rom, sel_sram, overlay_active;

  int checks = 0;
  int fails  = 0;

  // Shadow of the programmed state, kept from the requirements.
  logic [7:0] m_bank [4];
  logic       m_lock;

  always #10 clk = ~clk;

  cart_bank_map u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata),
    .rom_mask(rom_mask), .sram_mask(sram_mask), .sram_present(sram_present),
    .lin_addr(lin_addr), .sel_rom(sel_rom), .sel_sram(sel_sram),
    .overlay_active(overlay_active)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Returns {overlay, sram, rom, lin[27:0]}
  function automatic logic [30:0] model(input logic [19:0] a);
    logic [3:0]  s;
    logic [11:0] rb;
    s = a[19:16];
    if (s == 4'd0) return '0;
    if (s == 4'd1) begin
      if (!sram_present) return '0;
      return {3'b010, 4'h0, m_bank[1] & sram_mask, a[15:0]};
    end
    if (s == 4'd15 && !m_lock) return {3'b100, 28'h0};
    if (s == 4'd2)      rb = {4'h0, m_bank[2]};
    else if (s == 4'd3) rb = {4'h0, m_bank[3]};
    else                rb = {m_bank[0], s};
    return {3'b001, rb & rom_mask, a[15:0]};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a >= 8'hC0 && a <= 8'hC3) m_bank[a - 8'hC0] = d;
    if (a == 8'hA0 && d[0]) m_lock = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic xl(input string req, input logic [19:0] a);
    logic [30:0] e;
    @(negedge clk);
    cpu_addr = a;
    @(negedge clk);
    e = model(a);
    check(req, {33'b0, overlay_active, sel_sram, sel_rom, lin_addr}, {33'b0, e});
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240517));
    for (int i = 0; i < 4; i++) m_bank[i] = 8'hFF;
    m_lock = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(8'hC0, d); check("R1 bank0 reset read", 64'(d), 64'h2F);
    rd(8'hC1, d); check("R1 bank1 reset read", 64'(d), 64'hFF);
    rd(8'hC2, d); check("R1 bank2 reset read", 64'(d), 64'hFF);
    rd(8'hC3, d); check("R1 bank3 reset read", 64'(d), 64'hFF);
    rd(8'hA0, d); check("R1 ctl reset read",   64'(d), 64'h80);
    xl("R1 R2 reset bank0 window", 20'h4ABCD);

    // R8: overlay while unlocked
    xl("R8 overlay before lock", 20'hF1234);
    xl("R5 segment 0", 20'h0FFFF);

    // R9: read-back formatting
    wr(8'hC0, 8'h35); rd(8'hC0, d); check("R9 bank0 tagged read", 64'(d), 64'h25);
    wr(8'hC1, 8'hA7); rd(8'hC1, d); check("R9 bank1 read back", 64'(d), 64'hA7);
    wr(8'hC3, 8'h5C); rd(8'hC3, d); check("R9 bank3 read back", 64'(d), 64'h5C);

    // R11: read data holds while io_rd is low
    @(negedge clk); io_addr = 8'hC1;
    @(negedge clk); check("R11 rdata hold", 64'(io_rdata), 64'h5C);

    // R11: translation latency of one clock
    @(negedge clk); cpu_addr = 20'h20000;
    @(negedge clk); cpu_addr = 20'h5000F;
    #1; check("R11 output not yet updated", 64'(lin_addr), 64'({4'h0, m_bank[2], 16'h0000}));
    @(negedge clk);
    check("R11 output after one clock", 64'(lin_addr), 64'({m_bank[0], 4'h5, 16'h000F}));

    // R3: SRAM gating
    sram_present = 1'b0; xl("R3 no sram", 20'h11111);
    sram_present = 1'b1; xl("R3 sram mapped", 20'h1BEEF);

    // R12: mask wrap, directed
    wr(8'hC2, 8'hFF);
    rom_mask = 12'h00F; xl("R12 R4 rom wrap seg2", 20'h2C0DE);
    sram_mask = 8'h03;  xl("R12 sram wrap", 20'h10042);
    rom_mask = 12'hFFF; sram_mask = 8'hFF;

    // Random mix, unlocked: R2 R3 R4 R5 R8 R12
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) == 0) wr(8'hC0 + 8'($urandom_range(0, 3)), 8'($urandom));
      if ($urandom_range(0, 7) == 0) begin
        rom_mask  = ($urandom_range(0, 1) == 0) ? 12'hFFF : 12'($urandom);
        sram_mask = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      end
      sram_present = 1'($urandom);
      xl("R2 R3 R4 R5 R8 R12 random unlocked", 20'($urandom));
    end

    // R6 R7: lock is sticky, handshake bit
    wr(8'hA0, 8'h01); rd(8'hA0, d); check("R6 lock set", 64'(d), 64'h81);
    wr(8'hA0, 8'h00); rd(8'hA0, d); check("R6 lock stays after zero write", 64'(d), 64'h81);
    wr(8'hA0, 8'h7E); rd(8'hA0, d); check("R7 ctl bits and handshake", 64'(d), 64'hFF);
    wr(8'hA0, 8'h04); rd(8'hA0, d); check("R7 ctl bits rewritten", 64'(d), 64'h85);

    // R8: overlay gone once locked
    rom_mask = 12'hFFF;
    xl("R8 R2 segment 15 after lock", 20'hF1234);

    // R10: unmapped ports
    rd(8'h55, d); check("R10 open bus 0x55", 64'(d), 64'h90);
    rd(8'hC4, d); check("R10 open bus 0xC4", 64'(d), 64'h90);
    wr(8'h55, 8'h00); wr(8'hC4, 8'h00); wr(8'hBF, 8'h00);
    rd(8'hC0, d); check("R10 bank0 untouched", 64'(d), 64'(8'h20 | {4'h0, m_bank[0][3:0]}));
    rd(8'hC2, d); check("R10 bank2 untouched", 64'(d), 64'(m_bank[2]));
    xl("R10 translation untouched", 20'h3AAAA);

    // Random mix, locked
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) == 0) wr(8'hC0 + 8'($urandom_range(0, 3)), 8'($urandom));
      if ($urandom_range(0, 5) == 0) wr(8'hA0, 8'($urandom) & 8'hFE);
      sram_present = 1'($urandom);
      rom_mask = ($urandom_range(0, 1) == 0) ? 12'hFFF : 12'($urandom);
      xl("R2 R4 R6 R8 random locked", 20'($urandom));
    end

    // R1: reset clears lock again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) m_bank[i] = 8'hFF;
    m_lock = 1'b0;
    rd(8'hA0, d); check("R1 lock cleared by reset", 64'(d), 64'h80);
    xl("R1 R8 overlay back after reset", 20'hF0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule